// File: doc/BRIEF.md
# Error Detect, Capture and Report Unit

This block sits beside the ECC and parity checkers of a cache or SRAM array. It turns their per-cycle error events into software-visible state and an interrupt. Each error type has its own event strobe. A shared bus carries the address, attributes, high and low data words and access information of the access that failed. The unit keeps four things:

- a sticky detect register,
- a per-type disable register,
- a per-type interrupt-enable register,
- a set of capture registers that hold the details of the first error only.

When an error of an enabled type arrives, the unit raises a flag in the same cycle. The flag travels back to the requester with the read data, so that the corrupt word is dropped. Software reaches every register through a simple word-addressed read/write bus. Reads are combinational from the current offset. A write takes effect at the next clock edge. The interrupt is a level and is registered.

Top module: `err_capture_unit`

## Requirements
- R1: An event on type k whose disable bit is clear sets detect bit k at the next edge. The bit then stays set until software clears it.
- R2: An event on a disabled type sets no detect bit, asserts no read-data flag and does not load the capture registers.
- R3: `rd_err_o` is high in the same cycle as any event on a type that is not disabled.
- R4: The capture registers (address, attributes, data high, data low, access) load from the first enabled error only. Later errors set their detect bits but leave the captured values unchanged.
- R5: Writing the detect register clears each bit where the write data holds a 1. Writing 0 leaves a bit alone, and no write ever sets a bit.
- R6: A detect bit is set whatever its interrupt-enable bit holds. `irq_o` is the OR over all types of (detect AND enable), delayed by one register stage.
- R7: Bits are numbered big-endian, with bit 0 as the MSB of the 32-bit word. Type k uses bit TYPE_BASE+k, which is data-word bit 31-(TYPE_BASE+k). The default types map as follows:
  - multi-bit data ECC: 0x1000_0000
  - single-bit data ECC: 0x0800_0000
  - tag parity: 0x0400_0000
  - configuration error: 0x0200_0000

  So a write of 0x0200_0000 clears only bit 6.
- R8: Register offsets are: 0 detect, 1 disable, 2 interrupt-enable, 3 captured address, 4 captured attributes, 5 captured data high, 6 captured data low, 7 captured access info. Bits with no type read 0. The capture offsets ignore writes. Any other offset reads 0.
- R9: After reset every register reads 0 and `irq_o` is low. All types are then enabled for detection, interrupts are off and capture is armed.
- R10: If an error event and a clearing write hit the same detect bit in the same cycle, the bit ends up set.
- R11: Once the detect register has been cleared to all zeros, the next enabled error loads the capture registers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_vec | input | N_TYPES | One error strobe per type |
| ev_addr | input | ADDR_W | Address of the failing access |
| ev_attr | input | ATTR_W | Attributes of the failing access |
| ev_data_hi | input | DATA_W | High data word of the failing access |
| ev_data_lo | input | DATA_W | Low data word of the failing access |
| ev_acc | input | ACC_W | Access information of the failing access |
| reg_addr | input | 4 | Register word offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rd_err_o | output | 1 | Error flag returned with read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the following corner cases, and says what a faulty design would show for each:

- **Later errors overwriting the capture.** A second error arrives while a capture is held. A design that forgot the first-only rule would show the second address.
- **Re-arming too early.** A disabled error arrives after a full clear. A design that re-armed on the wrong condition would capture it.
- **Clear and error in the same cycle.** A clearing write and a new error hit the same bit. A design that let the clear win would read the bit back as zero.
- **Wrong bit numbering.** Writing 0x0200_0000 must clear only the configuration error. A design with little-endian numbering would clear nothing or the wrong type.
- **Ignored writes and disabled types.** Writing zeros, writing capture offsets and disabled-type events are checked for no visible effect. A design that wrongly honoured any of them would change a readback value or the read-data flag.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_DET   = 4'd0;
  localparam logic [REG_AW-1:0] OFS_DIS   = 4'd1;
  localparam logic [REG_AW-1:0] OFS_IEN   = 4'd2;
  localparam logic [REG_AW-1:0] OFS_CADDR = 4'd3;
  localparam logic [REG_AW-1:0] OFS_CATTR = 4'd4;
  localparam logic [REG_AW-1:0] OFS_CDHI  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_CDLO  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_CACC  = 4'd7;

  // big-endian bit number -> position in a logic [REG_W-1:0] vector
  function automatic int unsigned be_to_hw(input int unsigned be_bit);
    return REG_W - 1 - be_bit;
  endfunction
endpackage

// File: rtl/err_ctrl_regs.sv
module err_ctrl_regs #(
  parameter int unsigned N_TYPES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_dis,
  input  logic               wr_ien,
  input  logic [N_TYPES-1:0] wbits,
  output logic [N_TYPES-1:0] dis_q,
  output logic [N_TYPES-1:0] ien_q
);
  logic [N_TYPES-1:0] dis_d, ien_d;

  always_comb begin
    dis_d = dis_q;
    ien_d = ien_q;
    if (wr_dis) dis_d = wbits;
    if (wr_ien) ien_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_dis) dis_q <= dis_d;
      if (wr_ien) ien_q <= ien_d;
    end
  end
endmodule

// File: rtl/err_detect_log.sv
module err_detect_log #(
  parameter int unsigned N_TYPES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TYPES-1:0] ev,
  input  logic [N_TYPES-1:0] dis,
  input  logic [N_TYPES-1:0] ien,
  input  logic               clr_en,
  input  logic [N_TYPES-1:0] clr_bits,
  output logic [N_TYPES-1:0] det_q,
  output logic               hit_any,
  output logic               rearm,
  output logic               irq_o
);
  logic [N_TYPES-1:0] hit, clr_eff, det_d;
  logic               irq_d;

  always_comb begin
    hit     = ev & ~dis;
    clr_eff = clr_en ? clr_bits : '0;
    // a fresh event outranks a clear of the same bit
    det_d   = (det_q & ~clr_eff) | hit;
    hit_any = |hit;
    rearm   = (det_d == '0);
    irq_d   = |(det_q & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= '0;
      irq_o <= 1'b0;
    end else begin
      det_q <= det_d;
      irq_o <= irq_d;
    end
  end

  for (genvar k = 0; k < N_TYPES; k++) begin : g_chk
    // R1
    det_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[k] && !dis[k]) |=> det_q[k]);
    // R2
    dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[k] && dis[k] && !det_q[k]) |=> !det_q[k]);
    // R5
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_q[k] && !ev[k]) |=> !det_q[k]);
  end

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & ien) == '0) |=> !irq_o);
  // R6
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((det_q & ien) != '0) |=> irq_o);
endmodule

// File: rtl/err_first_capture.sv
module err_first_capture #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ATTR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ACC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_any,
  input  logic              rearm,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ATTR_W-1:0] in_attr,
  input  logic [DATA_W-1:0] in_dhi,
  input  logic [DATA_W-1:0] in_dlo,
  input  logic [ACC_W-1:0]  in_acc,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [ATTR_W-1:0] cap_attr,
  output logic [DATA_W-1:0] cap_dhi,
  output logic [DATA_W-1:0] cap_dlo,
  output logic [ACC_W-1:0]  cap_acc
);
  logic vld_q, vld_d, load;

  always_comb begin
    load  = hit_any && !vld_q;
    vld_d = rearm ? 1'b0 : (vld_q | hit_any);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      cap_addr <= '0;
      cap_attr <= '0;
      cap_dhi  <= '0;
      cap_dlo  <= '0;
      cap_acc  <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        cap_addr <= in_addr;
        cap_attr <= in_attr;
        cap_dhi  <= in_dhi;
        cap_dlo  <= in_dlo;
        cap_acc  <= in_acc;
      end
    end
  end

  // R4
  hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> ($stable(cap_addr) && $stable(cap_attr) && $stable(cap_dhi)
               && $stable(cap_dlo) && $stable(cap_acc)));
endmodule

// File: rtl/err_capture_unit.sv
module err_capture_unit
  import err_cap_pkg::*;
#(
  parameter int unsigned N_TYPES   = 4,
  parameter int unsigned TYPE_BASE = 3,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ATTR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ACC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_TYPES-1:0]   ev_vec,
  input  logic [ADDR_W-1:0]    ev_addr,
  input  logic [ATTR_W-1:0]    ev_attr,
  input  logic [DATA_W-1:0]    ev_data_hi,
  input  logic [DATA_W-1:0]    ev_data_lo,
  input  logic [ACC_W-1:0]     ev_acc,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 rd_err_o,
  output logic                 irq_o
);
  logic [N_TYPES-1:0] dis_q, ien_q, det_q, wbits;
  logic               wr_det, wr_dis, wr_ien, rearm;
  logic [REG_W-1:0]   det_img, dis_img, ien_img;
  logic [ADDR_W-1:0]  cap_addr;
  logic [ATTR_W-1:0]  cap_attr;
  logic [DATA_W-1:0]  cap_dhi, cap_dlo;
  logic [ACC_W-1:0]   cap_acc;

  always_comb begin
    wr_det  = reg_wr && (reg_addr == OFS_DET);
    wr_dis  = reg_wr && (reg_addr == OFS_DIS);
    wr_ien  = reg_wr && (reg_addr == OFS_IEN);
    det_img = '0;
    dis_img = '0;
    ien_img = '0;
    for (int k = 0; k < int'(N_TYPES); k++) begin
      wbits[k]                           = reg_wdata[be_to_hw(TYPE_BASE + k)];
      det_img[be_to_hw(TYPE_BASE + k)]   = det_q[k];
      dis_img[be_to_hw(TYPE_BASE + k)]   = dis_q[k];
      ien_img[be_to_hw(TYPE_BASE + k)]   = ien_q[k];
    end
  end

  err_ctrl_regs #(.N_TYPES(N_TYPES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_dis(wr_dis), .wr_ien(wr_ien),
    .wbits(wbits), .dis_q(dis_q), .ien_q(ien_q)
  );

  err_detect_log #(.N_TYPES(N_TYPES)) u_det (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .dis(dis_q), .ien(ien_q),
    .clr_en(wr_det), .clr_bits(wbits), .det_q(det_q),
    .hit_any(rd_err_o), .rearm(rearm), .irq_o(irq_o)
  );

  err_first_capture #(
    .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W), .ACC_W(ACC_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .hit_any(rd_err_o), .rearm(rearm),
    .in_addr(ev_addr), .in_attr(ev_attr), .in_dhi(ev_data_hi),
    .in_dlo(ev_data_lo), .in_acc(ev_acc),
    .cap_addr(cap_addr), .cap_attr(cap_attr), .cap_dhi(cap_dhi),
    .cap_dlo(cap_dlo), .cap_acc(cap_acc)
  );

  always_comb begin
    case (reg_addr)
      OFS_DET:   reg_rdata = det_img;
      OFS_DIS:   reg_rdata = dis_img;
      OFS_IEN:   reg_rdata = ien_img;
      OFS_CADDR: reg_rdata = REG_W'(cap_addr);
      OFS_CATTR: reg_rdata = REG_W'(cap_attr);
      OFS_CDHI:  reg_rdata = REG_W'(cap_dhi);
      OFS_CDLO:  reg_rdata = REG_W'(cap_dlo);
      OFS_CACC:  reg_rdata = REG_W'(cap_acc);
      default:   reg_rdata = '0;
    endcase
  end

  // R3
  flag_sets_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |=> (det_q != '0));
endmodule

// File: tb/err_capture_unit_bench.sv
module err_capture_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ev_vec;
  logic [31:0] ev_addr, ev_data_hi, ev_data_lo;
  logic [7:0]  ev_attr, ev_acc;
  logic [3:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rd_err_o, irq_o;

  always #(CLK_P/2) clk = ~clk;

  err_capture_unit u_err_capture_unit (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .ev_addr(ev_addr),
    .ev_attr(ev_attr), .ev_data_hi(ev_data_hi), .ev_data_lo(ev_data_lo),
    .ev_acc(ev_acc), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_err_o(rd_err_o),
    .irq_o(irq_o)
  );

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  function automatic logic [31:0] be(input int b);
    return 32'h1 << (31 - b);
  endfunction

  localparam logic [31:0] T_MBE = 32'h1000_0000;
  localparam logic [31:0] T_SBE = 32'h0800_0000;
  localparam logic [31:0] T_TAG = 32'h0400_0000;
  localparam logic [31:0] T_CFG = 32'h0200_0000;

  // monitor: pops expected items and compares them with the ports
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = {31'd0, irq_o};
        default: act = {31'd0, rd_err_o};
      endcase
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    q.push_back('{kind, exp, req});
    wait (q.size() == 0);
    #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #(CLK_P/4);
    push(0, exp, req);
  endtask

  task automatic chk_irq(input logic exp, input string req);
    @(negedge clk);
    #(CLK_P/4);
    push(1, {31'd0, exp}, req);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic inject(input logic [3:0] v, input logic [31:0] a,
                        input logic exp_flag, input string req);
    @(negedge clk);
    ev_vec = v; ev_addr = a; ev_attr = a[7:0] ^ 8'h5A;
    ev_data_hi = ~a; ev_data_lo = a + 32'h11; ev_acc = a[15:8];
    #(CLK_P/4);
    push(2, {31'd0, exp_flag}, req);
    @(negedge clk);
    ev_vec = '0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ev_vec = '0; ev_addr = '0; ev_attr = '0;
    ev_data_hi = '0; ev_data_lo = '0; ev_acc = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(4'd0, 32'h0, "R9 detect");
    rd(4'd1, 32'h0, "R9 disable");
    rd(4'd2, 32'h0, "R9 int-enable");
    rd(4'd3, 32'h0, "R9 cap addr");
    chk_irq(1'b0, "R9 irq");

    // R1 R3 R4 R6: first error, single-bit type, interrupts off
    inject(4'b0010, 32'hA100_0040, 1'b1, "R3 flag on enabled error");
    rd(4'd0, T_SBE, "R1 detect set");
    chk_irq(1'b0, "R6 no irq while enable clear");
    rd(4'd3, 32'hA100_0040, "R4 cap addr");
    rd(4'd4, {24'd0, 8'h40 ^ 8'h5A}, "R4 cap attr");
    rd(4'd5, ~32'hA100_0040, "R4 cap data hi");
    rd(4'd6, 32'hA100_0051, "R4 cap data lo");
    rd(4'd7, 32'h0000_0000, "R4 cap access");

    // R4: later error sets its bit, capture unchanged
    inject(4'b0100, 32'hB200_1180, 1'b1, "R3 flag second error");
    rd(4'd0, T_SBE | T_TAG, "R1 sticky accumulate");
    rd(4'd3, 32'hA100_0040, "R4 first kept");
    rd(4'd7, 32'h0000_0000, "R4 first access kept");

    // R2: disabled type, R8 masked control bits
    wr(4'd1, T_CFG);
    rd(4'd1, T_CFG, "R8 disable readback");
    inject(4'b1000, 32'hC300_0000, 1'b0, "R2 no flag when disabled");
    rd(4'd0, T_SBE | T_TAG, "R2 no detect when disabled");
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h1E00_0000, "R8 unimplemented bits read 0");
    wr(4'd1, 32'h0);
    rd(4'd9, 32'h0, "R8 unmapped offset");

    // R6 interrupt masking
    wr(4'd2, T_TAG);
    chk_irq(1'b1, "R6 irq for enabled detected type");
    wr(4'd2, T_MBE);
    chk_irq(1'b0, "R6 irq off for enabled undetected type");

    // R5 clear semantics
    wr(4'd0, T_SBE);
    rd(4'd0, T_TAG, "R5 write one clears");
    wr(4'd0, 32'h0);
    rd(4'd0, T_TAG, "R5 write zero no effect");
    wr(4'd0, T_CFG | T_MBE);
    rd(4'd0, T_TAG, "R5 write never sets");

    // R7 big-endian numbering
    inject(4'b1000, 32'hD400_0000, 1'b1, "R3 flag cfg error");
    rd(4'd0, T_TAG | be(6), "R7 cfg at be bit 6");
    wr(4'd0, 32'h0200_0000);
    rd(4'd0, T_TAG, "R7 0x0200_0000 clears only bit 6");

    // R10 collision: event and clear on the same bit
    @(negedge clk);
    ev_vec = 4'b0001; ev_addr = 32'hE5; reg_addr = 4'd0;
    reg_wdata = T_MBE | T_TAG; reg_wr = 1'b1;
    @(negedge clk);
    ev_vec = '0; reg_wr = 1'b0;
    rd(4'd0, T_MBE, "R10 event beats clear");
    chk_irq(1'b1, "R6 irq after mbe with enable");

    // R11 re-arm and R2 disabled does not capture
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, 32'h0, "R11 fully cleared");
    rd(4'd3, 32'hA100_0040, "R11 capture persists after clear");
    wr(4'd1, T_SBE);
    inject(4'b0010, 32'hF600_0000, 1'b0, "R2 no flag disabled sbe");
    rd(4'd3, 32'hA100_0040, "R2 disabled event not captured");
    wr(4'd1, 32'h0);
    inject(4'b0101, 32'h1700_2200, 1'b1, "R3 flag multi-type");
    rd(4'd0, T_MBE | T_TAG, "R1 two types same cycle");
    rd(4'd3, 32'h1700_2200, "R11 capture re-armed");
    rd(4'd7, 32'h0000_0022, "R11 access re-captured");

    // R8 capture offsets ignore writes
    wr(4'd3, 32'hDEAD_BEEF);
    rd(4'd3, 32'h1700_2200, "R8 capture read-only");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule